// File: doc/BRIEF.md
# Serial Two-Wire Register Port with Word-Sized Auto-Increment

This block is an I2C target that opens a 13-bit register and RAM address space to an external controller. A transaction names the block by its 7-bit chip address, then loads the internal address pointer with a 2-byte subaddress, then moves data words. How many bytes make up one word depends on where the pointer sits: low RAM words are 4 bytes wide, the middle region holds 5-byte words, and the register region at the top uses 2-byte words. During a burst the pointer advances by one after each complete word. It keeps advancing when it crosses from one region into the next, and the width of the next word follows the region it lands in.

SCL and SDA are brought into the system clock domain through synchronizers. SDA is driven open-drain through a single pull-low enable. On the memory side the block presents a plain interface: an address, a right-aligned write word with a one-cycle write strobe, a one-cycle read request, and a read-data bus that is sampled with one cycle of latency. Reads work in the usual way. The controller writes the subaddress, issues a repeated start, sends the chip address with the read bit set, and acknowledges each byte it wants to continue with.

Top module: `i2c_regport`

## Requirements
- R1: The chip address is 7 bits. Its upper six bits are the parameter DEV_HI (default 6'b011010). Its least significant bit is the level on `addr_sel`. A first byte whose upper seven bits differ from this address is not acknowledged, and the transaction after it has no effect on the memory interface.
- R2: The last bit of the first byte selects the direction. 1 means a read from the target and 0 means a write to it.
- R3: In a write, the two bytes after the chip address form the subaddress, high byte first. Only the low 5 bits of the high byte are used, so the pointer is 13 bits wide.
- R4: The word size comes from the pointer. Addresses below 0x0800 use 4 bytes. Addresses 0x0800 to 0x0FFF use 5 bytes. Addresses 0x1000 and above use 2 bytes.
- R5: A written word is committed only when all of its bytes have arrived. The commit is a `mem_we` pulse one cycle long. `mem_wdata` holds the word right-aligned, the first byte received is the most significant, and every bit above the word's size is zero.
- R6: After each complete word, read or written, the pointer advances by exactly one. It keeps advancing across region boundaries, and the new word's size is taken from the new address.
- R7: After a repeated start with the read bit set, the block issues a one-cycle `mem_re` at the pointer. It takes `mem_rdata` one cycle later and shifts the word out most significant byte first, each byte MSB first. It issues a new `mem_re` only after the controller has acknowledged the last byte of the current word.
- R8: When the controller answers a read byte with NACK, the block stops transmitting and keeps SDA released.
- R9: A stop or a start condition abandons any partial word without a write. The next transaction begins again at the chip-address byte.
- R10: The block acknowledges a matching chip address, both subaddress bytes and every data byte written. It changes its SDA drive only while SCL is low.
- R11: `mem_we` and `mem_re` are never high in the same cycle, and each pulse lasts exactly one cycle. After reset SDA is released and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low |
| addr_sel | input | 1 | Chip address least significant bit |
| mem_addr | output | 13 | Word pointer to memory |
| mem_wdata | output | 48 | Write word, right-aligned |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read request |
| mem_rdata | input | 48 | Read word, valid the cycle after `mem_re` |

## Verification
A wrong bit or byte counter shows up as a misplaced acknowledge on the SDA line within the same byte. A wrong word-size lookup or byte index shows up at the next `mem_we` as a wrong data value or a wrong address, or in a read as bytes taken from the wrong lanes. The directed transfers are placed on both sides of the 0x0800 and 0x1000 region edges, so that a size error cannot stay hidden for more than one word. A pointer that advances early or late shows up as the wrong `mem_addr` on the following strobe. A partial word that survives a stop shows up as an extra write in the transfer that follows.

// File: rtl/i2crp_pkg.sv
package i2crp_pkg;
  // Bit-level protocol phase
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} st_t;
  // Meaning of the byte being received (or read mode)
  typedef enum logic [2:0] {K_DEV, K_SUBH, K_SUBL, K_DATA, K_READ} kind_t;
endpackage

// File: rtl/i2crp_sync.sv
module i2crp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  // Idle bus level is high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/i2crp_cond.sv
module i2crp_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // SDA moving while SCL stays high marks a bus condition
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2crp_wsize.sv
module i2crp_wsize #(
  parameter int          AW        = 13,
  parameter int          BW        = 3,
  parameter int unsigned LO_END    = 32'h0800,
  parameter int unsigned MID_END   = 32'h1000,
  parameter int          LO_BYTES  = 4,
  parameter int          MID_BYTES = 5,
  parameter int          HI_BYTES  = 2
) (
  input  logic [AW-1:0] addr,
  output logic [BW-1:0] nbytes
);
  always_comb begin
    if (32'(addr) < LO_END)       nbytes = BW'(LO_BYTES);
    else if (32'(addr) < MID_END) nbytes = BW'(MID_BYTES);
    else                          nbytes = BW'(HI_BYTES);
  end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2crp_pkg::*;
#(
  parameter logic [5:0]  DEV_HI      = 6'b011010,
  parameter int          SYNC_STAGES = 2,
  parameter int          AW          = 13,
  parameter int          MAXB        = 6,
  parameter int unsigned LO_END      = 32'h0800,
  parameter int unsigned MID_END     = 32'h1000,
  parameter int          LO_BYTES    = 4,
  parameter int          MID_BYTES   = 5,
  parameter int          HI_BYTES    = 2,
  localparam int         DW          = MAXB * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          addr_sel,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata
);
  localparam int BW = $clog2(MAXB + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic [BW-1:0] nb;

  i2crp_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (.clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  i2crp_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (.clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

  i2crp_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
  );

  st_t            st_q, st_n;
  kind_t          kind_q, kind_n;
  logic [3:0]     cnt_q, cnt_n;
  logic [7:0]     sh_q, sh_n;
  logic [AW-1:0]  addr_q, addr_n;
  logic [BW-1:0]  bidx_q, bidx_n;
  logic [DW-1:0]  wbuf_q, wbuf_n;
  logic [DW-1:0]  wdata_q, wdata_n;
  logic [DW-1:0]  rword_q;
  logic           we_q, we_n, re_q, re_n, re_d_q;
  logic           mack_q, mack_n, oe_q, oe_n;

  i2crp_wsize #(
    .AW(AW), .BW(BW), .LO_END(LO_END), .MID_END(MID_END),
    .LO_BYTES(LO_BYTES), .MID_BYTES(MID_BYTES), .HI_BYTES(HI_BYTES)
  ) u_wsize (.addr(addr_q), .nbytes(nb));

  logic [DW-1:0] wmask, newword, rshift;
  logic [7:0]    txbyte;
  logic          last_byte;

  always_comb begin
    wmask     = {DW{1'b1}} >> (8 * (MAXB - int'(nb)));
    newword   = {wbuf_q[DW-9:0], sh_q};
    rshift    = rword_q >> (8 * (int'(nb) - 1 - int'(bidx_q)));
    txbyte    = rshift[7:0];
    last_byte = (bidx_q == nb - 1'b1);
  end

  // Next-state logic
  always_comb begin
    st_n    = st_q;
    kind_n  = kind_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    addr_n  = addr_q;
    bidx_n  = bidx_q;
    wbuf_n  = wbuf_q;
    wdata_n = wdata_q;
    mack_n  = mack_q;
    we_n    = 1'b0;
    re_n    = 1'b0;

    // pointer moves the cycle after a committed word
    if (we_q) addr_n = addr_q + 1'b1;

    if (start_c) begin
      st_n   = ST_RX;
      kind_n = K_DEV;
      cnt_n  = '0;
    end else if (stop_c) begin
      st_n = ST_IDLE;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            st_n = ST_ACK;
            case (kind_q)
              K_DEV: begin
                if (sh_q[7:1] != {DEV_HI, addr_sel}) begin
                  st_n = ST_IDLE;
                end else if (sh_q[0]) begin
                  kind_n = K_READ;
                  bidx_n = '0;
                  re_n   = 1'b1;
                end else begin
                  kind_n = K_SUBH;
                end
              end
              K_SUBH: begin
                addr_n[AW-1:8] = sh_q[AW-9:0];
                kind_n         = K_SUBL;
              end
              K_SUBL: begin
                addr_n[7:0] = sh_q;
                bidx_n      = '0;
                wbuf_n      = '0;
                kind_n      = K_DATA;
              end
              K_DATA: begin
                if (last_byte) begin
                  we_n    = 1'b1;
                  wdata_n = newword & wmask;
                  wbuf_n  = '0;
                  bidx_n  = '0;
                end else begin
                  wbuf_n = newword;
                  bidx_n = bidx_q + 1'b1;
                end
              end
              default: st_n = ST_IDLE;
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            st_n  = (kind_q == K_READ) ? ST_TX : ST_RX;
            cnt_n = '0;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) st_n = ST_MACK;
            else               cnt_n = cnt_q + 4'd1;
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
            if (!sda_s) begin
              if (last_byte) begin
                bidx_n = '0;
                addr_n = addr_q + 1'b1;
                re_n   = 1'b1;
              end else begin
                bidx_n = bidx_q + 1'b1;
              end
            end
          end else if (scl_fall) begin
            st_n  = mack_q ? ST_TX : ST_IDLE;
            cnt_n = '0;
          end
        end
        default: ;
      endcase
    end

    oe_n = (st_n == ST_ACK) || (st_n == ST_TX && !txbyte[~cnt_n[2:0]]);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      kind_q  <= K_DEV;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      bidx_q  <= '0;
      wbuf_q  <= '0;
      wdata_q <= '0;
      mack_q  <= 1'b0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      re_d_q  <= 1'b0;
      oe_q    <= 1'b0;
      rword_q <= '0;
    end else begin
      st_q    <= st_n;
      kind_q  <= kind_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      addr_q  <= addr_n;
      bidx_q  <= bidx_n;
      wbuf_q  <= wbuf_n;
      wdata_q <= wdata_n;
      mack_q  <= mack_n;
      we_q    <= we_n;
      re_q    <= re_n;
      re_d_q  <= re_q;
      oe_q    <= oe_n;
      if (re_d_q) rword_q <= mem_rdata;
    end
  end

  assign sda_oe    = oe_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_we    = we_q;
  assign mem_re    = re_q;

  // R11
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !mem_we);
  // R11
  re_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_re |=> !mem_re);
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({mem_we, mem_re}));
  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> mem_addr == $past(mem_addr) + 1'b1);
  // R5
  wdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata & ~wmask) == '0);
  // R10
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));
endmodule

// File: tb/sim_i2c_regport.sv
`timescale 1ns/1ps
module sim_i2c_regport;
  logic        clk, rst_n;
  logic        m_scl, m_sda_low, addr_sel;
  logic        sda_oe, mem_we, mem_re;
  logic [12:0] mem_addr;
  logic [47:0] mem_wdata, mem_rdata;
  wire         sda_bus = ~(m_sda_low | sda_oe);

  int tests = 0, fails = 0;
  int wn = 0, rn = 0, clash = 0;
  logic [12:0] wl_a [0:31];
  logic [47:0] wl_d [0:31];

  i2c_regport u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [47:0] pat(input logic [12:0] a);
    return {3'b101, a, 3'b101, a, 3'b101, a};
  endfunction

  // memory model: one-cycle read latency, write log
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= pat(mem_addr);
    if (mem_we && wn < 32) begin
      wl_a[wn] <= mem_addr;
      wl_d[wn] <= mem_wdata;
    end
    if (mem_we) wn <= wn + 1;
    if (mem_re) rn <= rn + 1;
    if (mem_we && mem_re) clash <= clash + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; tick(5);
    m_scl = 1'b1;     tick(10);
    m_sda_low = 1'b1; tick(10);
    m_scl = 1'b0;     tick(2);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; tick(5);
    m_scl = 1'b1;     tick(10);
    m_sda_low = 1'b0; tick(10);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i]; tick(10);
      m_scl = 1'b1;      tick(10);
      m_scl = 1'b0;      tick(2);
    end
    m_sda_low = 1'b0; tick(10);
    m_scl = 1'b1;     tick(5);
    ack = ~sda_bus;   tick(5);
    m_scl = 1'b0;     tick(2);
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    m_sda_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick(10);
      m_scl = 1'b1; tick(5);
      b = {b[6:0], sda_bus}; tick(5);
      m_scl = 1'b0;
    end
    m_sda_low = give_ack; tick(10);
    m_scl = 1'b1;         tick(10);
    m_scl = 1'b0;         tick(3);
    m_sda_low = 1'b0;
  endtask

  // write transaction: dev byte, subaddress, n data bytes from buf
  logic [7:0] wbuf [0:15];
  task automatic wr_txn(input logic [6:0] dev, input logic [15:0] sub, input int n,
                        input string tag, input bit expect_ack);
    bit a, all;
    bus_start();
    wr_byte({dev, 1'b0}, a);
    chk(a == expect_ack, {tag, " chip ack"}, 64'(a), 64'(expect_ack));
    all = 1'b1;
    if (a) begin
      wr_byte(sub[15:8], a); all &= a;
      wr_byte(sub[7:0], a);  all &= a;
      for (int i = 0; i < n; i++) begin
        wr_byte(wbuf[i], a); all &= a;
      end
      chk(all, {tag, " R10 data acks"}, 64'(all), 64'd1);
    end
    bus_stop();
    tick(10);
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R11 reset state",
        64'({sda_oe, mem_we, mem_re}), 64'd0);
  endtask

  task automatic t_mismatch();
    int w0;
    w0 = wn;
    wbuf[0] = 8'h55; wbuf[1] = 8'h66;
    wr_txn(7'h35, 16'h1000, 2, "R1 mismatch", 1'b0);
    chk(wn == w0, "R1 no write on foreign address", 64'(wn - w0), 64'd0);
    chk(sda_oe == 1'b0, "R1 sda released", 64'(sda_oe), 64'd0);
  endtask

  task automatic t_reg_burst();
    int w0;
    w0 = wn;
    wbuf[0] = 8'hAB; wbuf[1] = 8'hCD; wbuf[2] = 8'h12; wbuf[3] = 8'h34;
    wr_txn(7'h34, 16'h1005, 4, "R2 write", 1'b1);
    chk(wn - w0 == 2, "R5 two commits", 64'(wn - w0), 64'd2);
    chk(wl_a[w0] == 13'h1005 && wl_d[w0] == 48'hABCD, "R4 R5 first 2-byte word",
        {3'b0, wl_a[w0], wl_d[w0]}, {3'b0, 13'h1005, 48'hABCD});
    chk(wl_a[w0+1] == 13'h1006 && wl_d[w0+1] == 48'h1234, "R6 next word",
        {3'b0, wl_a[w0+1], wl_d[w0+1]}, {3'b0, 13'h1006, 48'h1234});
  endtask

  task automatic t_cross();
    int w0;
    w0 = wn;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wbuf[4] = 8'h55; wbuf[5] = 8'h66; wbuf[6] = 8'h77; wbuf[7] = 8'h88; wbuf[8] = 8'h99;
    // high byte E7: top three bits must be dropped -> 0x07FF
    wr_txn(7'h34, 16'hE7FF, 9, "R3 cross", 1'b1);
    chk(wn - w0 == 2, "R6 commits across edge", 64'(wn - w0), 64'd2);
    chk(wl_a[w0] == 13'h07FF && wl_d[w0] == 48'h11223344, "R3 R4 4-byte word at 0x07FF",
        {3'b0, wl_a[w0], wl_d[w0]}, {3'b0, 13'h07FF, 48'h11223344});
    chk(wl_a[w0+1] == 13'h0800 && wl_d[w0+1] == 48'h5566778899, "R6 R4 5-byte word at 0x0800",
        {3'b0, wl_a[w0+1], wl_d[w0+1]}, {3'b0, 13'h0800, 48'h5566778899});
  endtask

  task automatic t_partial();
    int w0;
    w0 = wn;
    wbuf[0] = 8'h77;
    wr_txn(7'h34, 16'h1010, 1, "R9 partial", 1'b1);
    chk(wn == w0, "R9 partial word dropped", 64'(wn - w0), 64'd0);
    wbuf[0] = 8'hBE; wbuf[1] = 8'hEF;
    wr_txn(7'h34, 16'h1010, 2, "R9 refill", 1'b1);
    chk(wn - w0 == 1 && wl_a[w0] == 13'h1010 && wl_d[w0] == 48'hBEEF, "R9 fresh word after stop",
        {3'b0, wl_a[w0], wl_d[w0]}, {3'b0, 13'h1010, 48'hBEEF});
  endtask

  task automatic t_read();
    bit a;
    int r0;
    logic [7:0]  b;
    logic [47:0] w1, w2;
    logic [55:0] got, exp;
    r0 = rn;
    w1 = pat(13'h0FFF);
    w2 = pat(13'h1000);
    exp = {w1[39:0], w2[15:0]};
    bus_start();
    wr_byte({7'h34, 1'b0}, a);
    wr_byte(8'h0F, a);
    wr_byte(8'hFF, a);
    bus_start();
    wr_byte({7'h34, 1'b1}, a);
    chk(a, "R2 read address ack", 64'(a), 64'd1);
    got = '0;
    for (int i = 0; i < 7; i++) begin
      rd_byte(i != 6, b);
      got = {got[47:0], b};
    end
    chk(got == exp, "R7 R4 R6 read bytes across 0x1000", 64'(got), 64'(exp));
    chk(rn - r0 == 2, "R7 one request per word", 64'(rn - r0), 64'd2);
    tick(5);
    chk(sda_oe == 1'b0, "R8 released after NACK", 64'(sda_oe), 64'd0);
    tick(20);
    chk(sda_oe == 1'b0 && rn - r0 == 2, "R8 no further transmit", 64'(rn - r0), 64'd2);
    bus_stop();
    tick(10);
  endtask

  task automatic t_pin();
    int w0;
    addr_sel = 1'b1;
    tick(4);
    w0 = wn;
    wbuf[0] = 8'h01; wbuf[1] = 8'h02;
    wr_txn(7'h34, 16'h1020, 2, "R1 pin high old address", 1'b0);
    wr_txn(7'h35, 16'h1020, 2, "R1 pin high new address", 1'b1);
    chk(wn - w0 == 1 && wl_a[w0] == 13'h1020 && wl_d[w0] == 48'h0102, "R1 write via pin-selected address",
        {3'b0, wl_a[w0], wl_d[w0]}, {3'b0, 13'h1020, 48'h0102});
    addr_sel = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; m_scl = 1'b1; m_sda_low = 1'b0; addr_sel = 1'b0;
    mem_rdata = '0;
    tick(6);
    rst_n = 1'b1;
    tick(6);
    t_reset();
    t_mismatch();
    t_reg_burst();
    t_cross();
    t_partial();
    t_read();
    t_pin();
    chk(clash == 0, "R11 strobes never overlap", 64'(clash), 64'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule